// File: doc/BRIEF.md
# Lockable Read-Only Region Write Filter

This block sits on the write path in front of a memory controller and enforces one physical read-only window. Software describes the window with two page numbers, a first page and a stop page, over a small 32-bit register port. A page number is turned into a physical address by shifting it left by the page shift and adding a fixed physical memory base. A one-way lock register completes the set. Until the lock is engaged, memory traffic passes untouched, so early software can fill in the data that will later be frozen.

After the lock is engaged, the two bound registers and the lock itself no longer accept writes, and any attempt gets an error response. Every memory write whose address lies between the first page's address (inclusive) and the stop page's address (exclusive) is consumed without being passed on. The requester sees an error pulse, and a sticky violation flag is set. Reads always pass. A window whose stop page is not above its first page protects nothing. Only reset releases the lock.

Top module: `rorgn_wfilter`

## Requirements
- R1: After reset both bound registers read 0, the lock reads 0, the violation flag is 0 and no error pulse is raised.
- R2: A register access is answered one cycle after it is accepted: `cfg_rsp_valid` is 1 and, for a read, `cfg_rdata` holds the first page (offset 0x7E4), the stop page (offset 0x7E8) or the lock state in bit 0 (offset 0x7EC). Every other offset reads 0 and ignores writes, and a write response carries data 0.
- R3: A write to offset 0x7EC with bit 0 of the data set to 1 engages the lock. A write there with bit 0 cleared leaves the lock state unchanged. No software write releases the lock.
- R4: While locked, writes to offsets 0x7E4, 0x7E8 and 0x7EC change nothing, and their response carries `cfg_err` = 1 for exactly that one response cycle.
- R5: While unlocked, every memory request is forwarded (`out_valid` = `in_valid`, `in_ready` = `out_ready`).
- R6: While locked with stop page > first page, a write whose address lies in the window is not forwarded (`out_valid` = 0). It is accepted (`in_ready` = 1 even when `out_ready` = 0), and `mem_err` pulses to 1 in the following cycle.
- R7: The window starts at PHYS_BASE + (first page << PAGE_SHIFT) inclusive and ends at PHYS_BASE + (stop page << PAGE_SHIFT) exclusive. The first address is blocked, the stop address and the address just below the start pass, and the address just below the stop is blocked.
- R8: Memory reads are forwarded whatever the address and lock state.
- R9: With stop page <= first page the window is empty and no write is blocked, even when locked.
- R10: `viol_sticky` becomes 1 in the cycle after the first blocked write and stays 1 until reset.
- R11: Addresses below PHYS_BASE are never blocked, even with a first page of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Register access request |
| cfg_write | input | 1 | 1 = register write, 0 = register read |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rsp_valid | output | 1 | Register response valid, one cycle after request |
| cfg_rdata | output | 32 | Register read data |
| cfg_err | output | 1 | Register write refused because of the lock |
| in_valid | input | 1 | Memory request valid from requester |
| in_write | input | 1 | Memory request is a write |
| in_addr | input | 40 | Memory request physical address |
| in_wdata | input | 64 | Memory write data |
| in_ready | output | 1 | Request accepted this cycle |
| out_valid | output | 1 | Request forwarded to memory |
| out_write | output | 1 | Forwarded write flag |
| out_addr | output | 40 | Forwarded address |
| out_wdata | output | 64 | Forwarded write data |
| out_ready | input | 1 | Memory side accepts request |
| mem_err | output | 1 | One-cycle error response for a blocked write |
| viol_sticky | output | 1 | Sticky flag: a write has been blocked since reset |

## Verification
The checker watches these on every cycle: the lock never drops, the bounds stay stable once locked, reads and unlocked traffic always pass, every error pulse is preceded by a refused write, and the violation flag never clears. Whether a particular address lands inside the window, including the exact inclusive and exclusive edges, the empty-window case and addresses below the physical base, can only be shown by the bench's scenarios. In those scenarios a behavioural model is compared with the block on every clock.

// File: rtl/rorgn_pkg.sv
// Package: shared offsets and register select type for the region filter.
// Assumes a byte-addressed 12-bit register window.
package rorgn_pkg;
    localparam int unsigned CFG_AW = 12;
    localparam logic [CFG_AW-1:0] OFF_FIRST = 12'h7E4;
    localparam logic [CFG_AW-1:0] OFF_STOP  = 12'h7E8;
    localparam logic [CFG_AW-1:0] OFF_LOCK  = 12'h7EC;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_FIRST,
        SEL_STOP,
        SEL_LOCK
    } reg_sel_e;

    // Map a register offset to the register it names.
    function automatic reg_sel_e decode_sel(input logic [CFG_AW-1:0] off);
        reg_sel_e s;
        unique case (off)
            OFF_FIRST: s = SEL_FIRST;
            OFF_STOP:  s = SEL_STOP;
            OFF_LOCK:  s = SEL_LOCK;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/rorgn_regs.sv
// Module: register file with a one-way lock. Holds the first and stop page
// numbers and the lock latch. Answers each access one cycle later.
// Assumes the requester issues at most one access per cycle.
module rorgn_regs
    import rorgn_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic              cfg_rsp_valid,
    output logic [DW-1:0]     cfg_rdata,
    output logic              cfg_err,
    output logic [DW-1:0]     first_q,
    output logic [DW-1:0]     stop_q,
    output logic              lock_q
);
    reg_sel_e      sel;
    logic          wr_any;
    logic          wr_ok;
    logic [DW-1:0] rd_mux;

    // Decode the accessed register and whether a write may land.
    always_comb begin
        sel    = decode_sel(cfg_addr);
        wr_any = cfg_valid && cfg_write && (sel != SEL_NONE);
        wr_ok  = wr_any && !lock_q;
    end

    // Select read data for the accessed register.
    always_comb begin
        unique case (sel)
            SEL_FIRST: rd_mux = first_q;
            SEL_STOP:  rd_mux = stop_q;
            SEL_LOCK:  rd_mux = {{(DW-1){1'b0}}, lock_q};
            default:   rd_mux = '0;
        endcase
    end

    // Hold bounds and lock; the lock only ever sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            stop_q  <= '0;
            lock_q  <= 1'b0;
        end else if (wr_ok) begin
            if (sel == SEL_FIRST) first_q <= cfg_wdata;
            if (sel == SEL_STOP)  stop_q  <= cfg_wdata;
            if (sel == SEL_LOCK && cfg_wdata[0]) lock_q <= 1'b1;
        end
    end

    // Register the access response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rsp_valid <= 1'b0;
            cfg_rdata     <= '0;
            cfg_err       <= 1'b0;
        end else begin
            cfg_rsp_valid <= cfg_valid;
            cfg_rdata     <= (cfg_valid && !cfg_write) ? rd_mux : '0;
            cfg_err       <= wr_any && lock_q;
        end
    end
endmodule

// File: rtl/rorgn_match.sv
// Module: window compare. Raises hit when the lock is set, the window is
// non-empty and the address lies in [start, stop). Bounds are page numbers
// scaled by PAGE_SHIFT and offset by PHYS_BASE; comparison is done in a
// width wide enough that no sum wraps.
module rorgn_match #(
    parameter int unsigned  AW         = 40,
    parameter int unsigned  DW         = 32,
    parameter int unsigned  PAGE_SHIFT = 14,
    parameter logic [63:0]  PHYS_BASE  = 64'h0000_0008_0000_0000
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] first_pg,
    input  logic [DW-1:0] stop_pg,
    input  logic          locked,
    output logic          hit
);
    localparam int unsigned WA = DW + PAGE_SHIFT + 1;
    localparam int unsigned WW = (WA > AW + 1) ? WA : AW + 1;
    localparam logic [WW-1:0] PB = WW'(PHYS_BASE[AW-1:0]);

    logic [WW-1:0] a_w;
    logic [WW-1:0] lo_w;
    logic [WW-1:0] hi_w;
    logic          nonempty;

    // Scale page numbers to byte addresses and test the window.
    always_comb begin
        a_w      = WW'(addr);
        lo_w     = PB + (WW'(first_pg) << PAGE_SHIFT);
        hi_w     = PB + (WW'(stop_pg) << PAGE_SHIFT);
        nonempty = stop_pg > first_pg;
        hit      = locked && nonempty && (a_w >= lo_w) && (a_w < hi_w);
    end
endmodule

// File: rtl/rorgn_gate.sv
// Module: write gate. Drops writes that hit the locked window, accepts them
// on the requester side, pulses an error the next cycle and keeps a sticky
// violation flag. Everything else passes straight through.
module rorgn_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_write,
    input  logic hit,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic mem_err,
    output logic viol_sticky
);
    logic drop;

    // Decide per cycle whether the current request is dropped.
    always_comb begin
        drop      = in_valid && in_write && hit;
        out_valid = in_valid && !drop;
        in_ready  = drop ? 1'b1 : out_ready;
    end

    // Error pulse for a dropped write and sticky violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_err     <= 1'b0;
            viol_sticky <= 1'b0;
        end else begin
            mem_err <= drop;
            if (drop) viol_sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/rorgn_wfilter.sv
// Module: top of the lockable read-only region write filter. Joins the
// register file, window compare and write gate. Address, write flag and
// data pass to the memory side unchanged; only the valid is gated.
// Assumes a single outstanding request handshake on each side.
module rorgn_wfilter #(
    parameter int unsigned AW         = 40,
    parameter int unsigned MW         = 64,
    parameter int unsigned PAGE_SHIFT = 14,
    parameter logic [63:0] PHYS_BASE  = 64'h0000_0008_0000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_valid,
    input  logic          cfg_write,
    input  logic [11:0]   cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic          cfg_rsp_valid,
    output logic [31:0]   cfg_rdata,
    output logic          cfg_err,
    input  logic          in_valid,
    input  logic          in_write,
    input  logic [AW-1:0] in_addr,
    input  logic [MW-1:0] in_wdata,
    output logic          in_ready,
    output logic          out_valid,
    output logic          out_write,
    output logic [AW-1:0] out_addr,
    output logic [MW-1:0] out_wdata,
    input  logic          out_ready,
    output logic          mem_err,
    output logic          viol_sticky
);
    localparam int unsigned DW = 32;

    logic [DW-1:0] first_q;
    logic [DW-1:0] stop_q;
    logic          lock_q;
    logic          hit;

    rorgn_regs #(.DW(DW)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_valid     (cfg_valid),
        .cfg_write     (cfg_write),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rdata     (cfg_rdata),
        .cfg_err       (cfg_err),
        .first_q       (first_q),
        .stop_q        (stop_q),
        .lock_q        (lock_q)
    );

    rorgn_match #(
        .AW         (AW),
        .DW         (DW),
        .PAGE_SHIFT (PAGE_SHIFT),
        .PHYS_BASE  (PHYS_BASE)
    ) u_match (
        .addr     (in_addr),
        .first_pg (first_q),
        .stop_pg  (stop_q),
        .locked   (lock_q),
        .hit      (hit)
    );

    rorgn_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_write    (in_write),
        .hit         (hit),
        .out_ready   (out_ready),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .mem_err     (mem_err),
        .viol_sticky (viol_sticky)
    );

    // Pass request payload to the memory side unchanged.
    always_comb begin
        out_write = in_write;
        out_addr  = in_addr;
        out_wdata = in_wdata;
    end
endmodule

// File: rtl/rorgn_wfilter_chk.sv
// Module: property checker for rorgn_wfilter, attached by bind below.
// Observes ports and the lock and bound state of the top.
module rorgn_wfilter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_valid,
    input logic        cfg_write,
    input logic        cfg_err,
    input logic        in_valid,
    input logic        in_write,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        mem_err,
    input logic        viol_sticky,
    input logic        lock_q,
    input logic [31:0] first_q,
    input logic [31:0] stop_q
);
    // R3: once engaged, the lock never drops before reset.
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R4: bounds stay frozen while locked.
    a_r4_bounds_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(first_q) && $stable(stop_q)));

    // R4: a register error only follows a write issued while locked.
    a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(lock_q && cfg_valid && cfg_write));

    // R5: unlocked traffic passes unchanged.
    a_r5_unlocked_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && in_valid) |-> (out_valid && (in_ready == out_ready)));

    // R6: a memory error only follows a write that was not forwarded.
    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        mem_err |-> $past(in_valid && in_write && !out_valid && in_ready));

    // R8: reads are always forwarded.
    a_r8_reads_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_write) |-> out_valid);

    // R10: the violation flag never clears before reset.
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol_sticky |=> viol_sticky);

    // R10: the flag is raised together with or after an error pulse.
    a_r10_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_sticky) |-> mem_err);
endmodule

bind rorgn_wfilter rorgn_wfilter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid   (cfg_valid),
    .cfg_write   (cfg_write),
    .cfg_err     (cfg_err),
    .in_valid    (in_valid),
    .in_write    (in_write),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .mem_err     (mem_err),
    .viol_sticky (viol_sticky),
    .lock_q      (lock_q),
    .first_q     (first_q),
    .stop_q      (stop_q)
);

// File: tb/rorgn_wfilter_tb.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenarios for each requirement.
module rorgn_wfilter_tb;
    localparam longint unsigned PB = 64'h0000_0008_0000_0000;
    localparam int PS = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rsp_valid, cfg_err;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0, in_write = 1'b0;
    logic [39:0] in_addr = '0;
    logic [63:0] in_wdata = '0;
    logic        in_ready, out_valid, out_write;
    logic [39:0] out_addr;
    logic [63:0] out_wdata;
    logic        out_ready = 1'b1;
    logic        mem_err, viol_sticky;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    rorgn_wfilter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rsp_valid(cfg_rsp_valid),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .in_valid(in_valid), .in_write(in_write), .in_addr(in_addr),
        .in_wdata(in_wdata), .in_ready(in_ready), .out_valid(out_valid),
        .out_write(out_write), .out_addr(out_addr), .out_wdata(out_wdata),
        .out_ready(out_ready), .mem_err(mem_err), .viol_sticky(viol_sticky)
    );

    always #5 clk = ~clk;

    // Reference model state
    longint unsigned m_first = 0, m_stop = 0;
    bit m_lock = 0, m_viol = 0;
    bit e_rsp = 0, e_cerr = 0, e_merr = 0;
    longint unsigned e_rdata = 0;

    function automatic bit m_hit(input longint unsigned a);
        longint unsigned lo = PB + (m_first << PS);
        longint unsigned hi = PB + (m_stop << PS);
        return m_lock && (m_stop > m_first) && a >= lo && a < hi;
    endfunction

    function automatic longint unsigned m_read(input logic [11:0] a);
        if (a == 12'h7E4) return m_first;
        if (a == 12'h7E8) return m_stop;
        if (a == 12'h7EC) return longint'(m_lock);
        return 0;
    endfunction

    task automatic chk(input string tag, input longint unsigned act,
                       input longint unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model update at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_first = 0; m_stop = 0; m_lock = 0; m_viol = 0;
            e_rsp = 0; e_cerr = 0; e_merr = 0; e_rdata = 0;
        end else begin
            bit is_reg;
            bit hit_now;
            is_reg  = (cfg_addr == 12'h7E4) || (cfg_addr == 12'h7E8) ||
                      (cfg_addr == 12'h7EC);
            hit_now = in_valid && in_write && m_hit(in_addr);
            e_rsp   = cfg_valid;
            e_rdata = (cfg_valid && !cfg_write) ? m_read(cfg_addr) : 0;
            e_cerr  = cfg_valid && cfg_write && is_reg && m_lock;
            e_merr  = hit_now;
            if (hit_now) m_viol = 1;
            if (cfg_valid && cfg_write && !m_lock) begin
                if (cfg_addr == 12'h7E4) m_first = cfg_wdata;
                if (cfg_addr == 12'h7E8) m_stop = cfg_wdata;
                if (cfg_addr == 12'h7EC && cfg_wdata[0]) m_lock = 1;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        bit blk;
        cyc++;
        blk = in_valid && in_write && m_hit(in_addr);
        chk("R5 R6 out_valid", out_valid, in_valid && !blk);
        chk("R5 R6 in_ready", in_ready, blk ? 1 : out_ready);
        chk("R2 cfg_rsp_valid", cfg_rsp_valid, e_rsp);
        chk("R2 cfg_rdata", cfg_rdata, e_rdata);
        chk("R4 cfg_err", cfg_err, e_cerr);
        chk("R6 mem_err", mem_err, e_merr);
        chk("R10 viol_sticky", viol_sticky, m_viol);
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic cfg_acc(input bit wr, input logic [11:0] a,
                           input logic [31:0] d,
                           output logic [31:0] rd, output logic er);
        @(posedge clk); #1;
        cfg_valid = 1'b1; cfg_write = wr; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_valid = 1'b0; cfg_write = 1'b0;
        @(negedge clk);
        rd = cfg_rdata; er = cfg_err;
    endtask

    task automatic mem_op(input bit wr, input longint unsigned a,
                          input bit exp_fwd, input string tag);
        @(posedge clk); #1;
        in_valid = 1'b1; in_write = wr; in_addr = a[39:0];
        in_wdata = {a[31:0], a[31:0]};
        @(negedge clk);
        chk(tag, out_valid, exp_fwd);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        chk({tag, " error pulse"}, mem_err, !exp_fwd && wr);
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] rd;
        logic er;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 viol after reset", viol_sticky, 0);
        chk("R1 mem_err after reset", mem_err, 0);
        cfg_acc(0, 12'h7E4, 0, rd, er); chk("R1 first page reset", rd, 0);
        cfg_acc(0, 12'h7E8, 0, rd, er); chk("R1 stop page reset", rd, 0);
        cfg_acc(0, 12'h7EC, 0, rd, er); chk("R1 lock reset", rd, 0);

        // Program window pages 4..8 and read back
        cfg_acc(1, 12'h7E4, 32'd4, rd, er); chk("R2 write rsp data", rd, 0);
        cfg_acc(1, 12'h7E8, 32'd8, rd, er);
        cfg_acc(0, 12'h7E4, 0, rd, er); chk("R2 first readback", rd, 4);
        cfg_acc(0, 12'h7E8, 0, rd, er); chk("R2 stop readback", rd, 8);
        cfg_acc(1, 12'h100, 32'hDEAD, rd, er);
        cfg_acc(0, 12'h100, 0, rd, er); chk("R2 unmapped reads 0", rd, 0);

        // Unlocked: window writes pass
        mem_op(1, PB + (4 << PS), 1, "R5 unlocked write in window");
        out_ready = 1'b0;
        mem_op(1, PB + (5 << PS), 1, "R5 unlocked write, memory stalled");
        out_ready = 1'b1;

        // Lock with bit0 clear does nothing; bit0 set locks
        cfg_acc(1, 12'h7EC, 32'h2, rd, er);
        cfg_acc(0, 12'h7EC, 0, rd, er); chk("R3 bit0 clear no lock", rd, 0);
        cfg_acc(1, 12'h7EC, 32'h1, rd, er); chk("R3 lock write no err", er, 0);
        cfg_acc(0, 12'h7EC, 0, rd, er); chk("R3 lock engaged", rd, 1);

        // Locked: register writes refused
        cfg_acc(1, 12'h7E4, 32'd0, rd, er); chk("R4 first write err", er, 1);
        @(negedge clk); chk("R4 err one cycle", cfg_err, 0);
        cfg_acc(1, 12'h7E8, 32'd99, rd, er); chk("R4 stop write err", er, 1);
        cfg_acc(1, 12'h7EC, 32'd0, rd, er); chk("R4 lock write err", er, 1);
        cfg_acc(0, 12'h7E4, 0, rd, er); chk("R4 first unchanged", rd, 4);
        cfg_acc(0, 12'h7E8, 0, rd, er); chk("R4 stop unchanged", rd, 8);
        cfg_acc(0, 12'h7EC, 0, rd, er); chk("R3 lock not released", rd, 1);

        // Edges of the window
        chk("R10 viol clear before block", viol_sticky, 0);
        mem_op(1, PB + (4 << PS) - 1, 1, "R7 below start passes");
        mem_op(1, PB + (4 << PS), 0, "R7 start blocked");
        chk("R10 viol set", viol_sticky, 1);
        mem_op(1, PB + (8 << PS) - 1, 0, "R7 last byte blocked");
        mem_op(1, PB + (8 << PS), 1, "R7 stop address passes");
        mem_op(0, PB + (6 << PS), 1, "R8 read in window passes");
        out_ready = 1'b0;
        mem_op(1, PB + (6 << PS), 0, "R6 blocked with memory stalled");
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 viol still set", viol_sticky, 1);

        // Empty window: stop == first
        do_reset();
        @(negedge clk); chk("R10 viol cleared by reset", viol_sticky, 0);
        cfg_acc(1, 12'h7E4, 32'd5, rd, er);
        cfg_acc(1, 12'h7E8, 32'd5, rd, er);
        cfg_acc(1, 12'h7EC, 32'd1, rd, er);
        mem_op(1, PB + (5 << PS), 1, "R9 empty window passes");
        cfg_acc(0, 12'h7EC, 0, rd, er); chk("R1 R3 lock after relock", rd, 1);

        // Window from page 0: addresses below the base pass
        do_reset();
        cfg_acc(1, 12'h7E4, 32'd0, rd, er);
        cfg_acc(1, 12'h7E8, 32'd2, rd, er);
        cfg_acc(1, 12'h7EC, 32'd1, rd, er);
        mem_op(1, PB - 1, 1, "R11 below base passes");
        mem_op(1, 64'h0, 1, "R11 address zero passes");
        mem_op(1, PB, 0, "R11 base address blocked");
        mem_op(0, PB, 1, "R8 read at base passes");

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule